// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data lines driven by a PS/2 keyboard and turns them into a stream of scan-code bytes in the system clock domain. Both lines pass through a synchroniser and a glitch filter. The receiver then finds the falling edges of the keyboard clock and samples data on them. It assembles each 11-bit frame: a start bit, eight data bits that arrive least significant first, a parity bit and a stop bit. A finished byte goes into a 32-entry ring buffer. The host drains that buffer through a valid/ready read port.

A frame timer starts on the first falling edge of a frame. If the eleven bits have not all arrived when it expires, the partial byte is discarded, the bit counter returns to zero and a one-cycle drop pulse is raised. The receiver is then ready for the next start bit. The timer is cleared whenever a frame completes. Parity is not checked. A byte that arrives while the buffer is full is lost, and a sticky overflow flag records the loss.

The read port follows these back-pressure rules. `out_valid` is high while the buffer holds at least one byte. `out_data` then shows the oldest byte and holds it until a pop. A pop happens on a rising clock edge where both `out_valid` and `out_ready` are high. `out_ready` has no effect while `out_valid` is low. The keyboard cannot be stalled, so when the buffer stays full, new bytes are dropped rather than held.

Top module: `ps2_kbd_rx`

## Requirements
- R1: After reset, `out_valid` is 0, `overflow` is 0 and `frame_drop` is 0.
- R2: The byte that is buffered is made of frame bits 1 to 8. Bit 1, the first bit after the start bit, becomes bit 0 of the byte. Data is sampled on each falling edge of the keyboard clock.
- R3: The parity bit is not checked. A frame whose parity is wrong is still buffered with its data unchanged.
- R4: Bytes leave in the order they arrived. A pop happens only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` holds its value. `out_ready` has no effect when `out_valid` is low.
- R5: The buffer holds 32 bytes. A 33rd byte that arrives while the buffer is full is discarded, and `overflow` rises and stays high until reset.
- R6: If a frame stalls for more than `TIMEOUT_CYC` system clock cycles after its first falling edge, the partial frame is discarded and `frame_drop` pulses high for exactly one cycle. The next complete frame is then received correctly.
- R7: A low pulse on the keyboard clock that lasts fewer than `FILT_LEN` system clock cycles is ignored. It starts no frame and adds no bit.
- R8: A complete frame, followed by an idle gap shorter than the timeout, produces no `frame_drop` pulse.
- R9: The head and tail pointers wrap modulo 32. Byte order is kept when a fill runs across the end of the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_clk_i | input | 1 | Clock line driven by the keyboard, idle high |
| kbd_dat_i | input | 1 | Data line driven by the keyboard, idle high |
| out_valid | output | 1 | The buffer holds at least one byte |
| out_ready | input | 1 | The host accepts `out_data` in this cycle |
| out_data | output | 8 | Oldest byte in the buffer |
| overflow | output | 1 | Sticky flag: a byte was lost because the buffer was full |
| frame_drop | output | 1 | One-cycle pulse when a stalled frame is discarded |

## Verification
A bit counter that is off by one shows up at the read port within the next frame. The byte comes out shifted by one position, or it is never committed and `out_valid` stays low. A fault in the pointers or the full flag shows up as a repeated or missing byte when the buffer is drained. The fault can also raise `overflow` too early or too late around the 32nd byte. A timer that never expires leaves `frame_drop` low after a stall, and the frame that follows decodes as garbage. A filter that lets short pulses through causes a spurious `frame_drop` one timeout later.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int DATA_BITS  = 8;
  localparam int FIRST_DATA = 1;
  localparam int LAST_DATA  = FIRST_DATA + DATA_BITS - 1;
  typedef logic [DATA_BITS-1:0] scan_byte_t;
  typedef enum logic [0:0] {LINE_CLK = 1'b0, LINE_DAT = 1'b1} line_sel_e;
endpackage

// File: rtl/ps2rx_line_filter.sv
module ps2rx_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_bit;
  logic [CW-1:0]          stable_cnt;
  logic                   level_q;
  logic                   prev_q;

  assign sync_bit = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q    <= 1'b1;
      stable_cnt <= '0;
    end else if (sync_bit == level_q) begin
      stable_cnt <= '0;
    end else if (stable_cnt == CW'(FILT_LEN - 1)) begin
      level_q    <= sync_bit;
      stable_cnt <= '0;
    end else begin
      stable_cnt <= stable_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_q;
  end

  assign level_o = level_q;
  assign fall_o  = prev_q & ~level_q;
  assign rise_o  = ~prev_q & level_q;

  AST_FILT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(sync_bit) == level_q)); // R7
endmodule

// File: rtl/ps2rx_framer.sv
module ps2rx_framer
  import ps2rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_fall,
  input  logic       clk_rise,
  input  logic       dat_lvl,
  output logic       push_o,
  output scan_byte_t push_data_o,
  output logic       frame_drop_o
);
  localparam int BCW = $clog2(FRAME_BITS + 1);
  localparam int TCW = $clog2(TIMEOUT_CYC + 1);

  logic [BCW-1:0] bit_cnt;
  scan_byte_t     shreg;
  logic [TCW-1:0] tmr;
  logic           active;
  logic           complete;
  logic           expired;
  logic           in_data;
  logic           drop_q;

  assign active   = (bit_cnt != '0);
  assign complete = clk_rise && (bit_cnt == BCW'(FRAME_BITS));
  assign expired  = active && !complete && (tmr == TCW'(TIMEOUT_CYC - 1));
  assign in_data  = (bit_cnt >= BCW'(FIRST_DATA)) && (bit_cnt <= BCW'(LAST_DATA));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (complete || expired) begin
      bit_cnt <= '0;
    end else if (clk_fall && bit_cnt < BCW'(FRAME_BITS)) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (in_data) shreg <= {dat_lvl, shreg[DATA_BITS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     tmr <= '0;
    else if (complete || expired)   tmr <= '0;
    else if (active)                tmr <= tmr + 1'b1;
    else                            tmr <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= expired;
  end

  assign push_o       = complete;
  assign push_data_o  = shreg;
  assign frame_drop_o = drop_q;

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BCW'(FRAME_BITS)); // R2
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |=> !drop_q); // R6
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clk_fall) |=> (tmr == '0)); // R6
endmodule

// File: rtl/ps2rx_ring.sv
module ps2rx_ring
  import ps2rx_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  scan_byte_t push_data_i,
  output logic       out_valid,
  input  logic       out_ready,
  output scan_byte_t out_data,
  output logic       overflow
);
  localparam int AW = $clog2(DEPTH);

  scan_byte_t   mem [DEPTH];
  logic [AW:0]  head;
  logic [AW:0]  tail;
  logic         empty;
  logic         full;
  logic         pop;
  logic         ovf_q;

  assign empty = (head == tail);
  assign full  = (head[AW] != tail[AW]) && (head[AW-1:0] == tail[AW-1:0]);
  assign pop   = out_ready && !empty;

  always_ff @(posedge clk) begin
    if (push_i && !full) mem[head[AW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_i && !full) head <= head + 1'b1;
      if (push_i && full)  ovf_q <= 1'b1;
      if (pop)             tail <= tail + 1'b1;
    end
  end

  assign out_valid = !empty;
  assign out_data  = mem[tail[AW-1:0]];
  assign overflow  = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R5
  AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop) |=> full); // R5
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4
endmodule

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx
  import ps2rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 200000,
  parameter int DEPTH       = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       overflow,
  output logic       frame_drop
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] fall;
  logic [NLINES-1:0] rise;
  logic              push;
  scan_byte_t        push_data;

  assign raw[LINE_CLK] = kbd_clk_i;
  assign raw[LINE_DAT] = kbd_dat_i;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ps2rx_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) i_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw[g]),
      .level_o(lvl[g]),
      .fall_o (fall[g]),
      .rise_o (rise[g])
    );
  end

  ps2rx_framer #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_fall    (fall[LINE_CLK]),
    .clk_rise    (rise[LINE_CLK]),
    .dat_lvl     (lvl[LINE_DAT]),
    .push_o      (push),
    .push_data_o (push_data),
    .frame_drop_o(frame_drop)
  );

  ps2rx_ring #(
    .DEPTH(DEPTH)
  ) i_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .push_data_i(push_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .overflow   (overflow)
  );

  logic unused_dat_edges;
  assign unused_dat_edges = fall[LINE_DAT] ^ rise[LINE_DAT];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !overflow && !frame_drop)); // R1
endmodule

// File: tb/test_ps2_kbd_rx.sv
module test_ps2_kbd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 30;
  localparam int TMO        = 3000;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kclk = 1'b1;
  logic       kdat = 1'b1;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       overflow;
  logic       frame_drop;

  int checks = 0;
  int fails  = 0;
  int drops  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_kbd_rx #(.TIMEOUT_CYC(TMO)) i_ps2_kbd_rx (
    .clk(clk), .rst_n(rst_n), .kbd_clk_i(kclk), .kbd_dat_i(kdat),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .overflow(overflow), .frame_drop(frame_drop)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && frame_drop) drops <= drops + 1;
  end

  initial begin
    wait (cycles >= WD_LIMIT);
    fails = fails + 1;
    $display("FAIL watchdog (all R) actual=%0d expected<%0d", cycles, WD_LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    kdat = b;
    wait_cyc(HP);
    kclk = 1'b0;
    wait_cyc(HP);
    kclk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic bad_par);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit((~^b) ^ bad_par);
    send_bit(1'b1);
    kdat = 1'b1;
    wait_cyc(20);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    int n = 0;
    while (!out_valid && n < 200) begin
      wait_cyc(1);
      n++;
    end
    chk(req, int'(out_valid), 1);
    chk(req, int'(out_data), int'(exp));
    out_ready = 1'b1;
    wait_cyc(1);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 frame_drop", int'(frame_drop), 0);
  endtask

  task automatic t_basic;
    int d0 = drops;
    send_frame(8'h1C, 1'b0);
    send_frame(8'hA5, 1'b0);
    send_frame(8'h80, 1'b0);
    out_ready = 1'b1;
    chk("R4 hold before pop", int'(out_data), 8'h1C);
    out_ready = 1'b0;
    wait_cyc(3);
    chk("R4 stable while not ready", int'(out_data), 8'h1C);
    pop_expect("R2 lsb first 1C", 8'h1C);
    pop_expect("R2 lsb first A5", 8'hA5);
    pop_expect("R4 order 80", 8'h80);
    chk("R4 empty after drain", int'(out_valid), 0);
    chk("R8 no drop on good frames", drops - d0, 0);
  endtask

  task automatic t_parity;
    send_frame(8'h5A, 1'b1);
    pop_expect("R3 bad parity kept", 8'h5A);
  endtask

  task automatic t_ready_idle;
    out_ready = 1'b1;
    wait_cyc(5);
    out_ready = 1'b0;
    send_frame(8'h3E, 1'b0);
    pop_expect("R4 ready while empty ignored", 8'h3E);
    chk("R4 empty again", int'(out_valid), 0);
  endtask

  task automatic t_timeout;
    int d0 = drops;
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    kdat = 1'b1;
    wait_cyc(TMO + 500);
    chk("R6 one drop pulse", drops - d0, 1);
    chk("R6 nothing buffered", int'(out_valid), 0);
    send_frame(8'hC3, 1'b0);
    pop_expect("R6 next frame after drop", 8'hC3);
  endtask

  task automatic t_glitch;
    int d0 = drops;
    for (int k = 0; k < 3; k++) begin
      kclk = 1'b0;
      wait_cyc(2);
      kclk = 1'b1;
      wait_cyc(10);
    end
    wait_cyc(TMO + 500);
    chk("R7 glitch started no frame", drops - d0, 0);
    chk("R7 glitch buffered nothing", int'(out_valid), 0);
    send_frame(8'h69, 1'b0);
    pop_expect("R7 frame after glitch", 8'h69);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 32; i++) send_frame(8'(i * 7 + 3), 1'b0);
    chk("R5 no overflow at 32", int'(overflow), 0);
    send_frame(8'hEE, 1'b0);
    chk("R5 overflow set", int'(overflow), 1);
    for (int i = 0; i < 32; i++) pop_expect("R9 wrap order", 8'(i * 7 + 3));
    chk("R5 33rd dropped", int'(out_valid), 0);
    chk("R5 overflow sticky", int'(overflow), 1);
  endtask

  initial begin
    wait_cyc(5);
    t_reset;
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset;
    t_basic;
    t_parity;
    t_ready_idle;
    t_timeout;
    t_glitch;
    t_fill;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule